// File: doc/BRIEF.md
# Programmable power-good and reset supervisor

This block drives two supervisor pins from the power-good status of five regulators, named A through E. The first pin is a power-good flag. The second pin is a reset line, and it follows regulator A. One 8-bit control byte sets three things: the active level of each pin, which regulators the power-good flag watches, and how long each pin waits before it shows good.

Each delay counts whole ticks of a one-millisecond enable pulse, and the watched condition must stay good for the whole count. Any loss of good sends the pin back to its fail or reset level on the next clock. Both pins work only while regulator B is enabled. While B is off, each pin sits at its fail or reset level.

The block is meant to sit behind a register interface that holds the control byte. It sits in front of the two board pins.

Top module: `pwr_supervisor`

## Requirements
- R1: Control bit 7 sets the power-good pin level. With 0 the pin is low on good and high on fail. With 1 the pin is high on good and low on fail. A change of this bit moves the pin within the same cycle.
- R2: Control bit 6 sets the reset pin level. With 0 the pin is low on good and high during reset. With 1 the pin is high on good and low during reset.
- R3: Control bits 5:4 choose what the power-good flag watches. 00 means A, C, D and E are all good, 01 means E only, 10 means C only, and 11 means D only. The regulator good input bit 0 is A, bit 1 is B, bit 2 is C, bit 3 is D and bit 4 is E.
- R4: Control bits 3:2 set the power-good delay. 11 means no delay, 10 means SHORT_MS ticks, 01 means MID_MS ticks and 00 means LONG_MS ticks.
- R5: The reset pin watches regulator A only. Its delay is set by bits 1:0 as follows: 11 means no delay, 01 means SHORT_MS ticks, 10 means MID_MS ticks and 00 means LONG_MS ticks.
- R6: Ticks count only while the watched condition is good and the pin is not yet good. A pin shows good on the clock after N ticks have been counted. With no delay, it shows good on the clock after the condition is first sampled good.
- R7: A pin returns to its fail or reset level on the clock after its watched condition is sampled not good.
- R8: While the regulator B enable is low, both pins go to their fail or reset level, at the selected polarity, on the next clock. Both delay counts are cleared, so after B is enabled again the full delay is needed.
- R9: Any change of the control byte restarts a delay count that is running. A pin that already shows good stays good.
- R10: During and after asynchronous reset, both pins sit at their fail or reset level. The stored copy of the control byte, used to detect changes, resets to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_good | input | 5 | Good status per regulator, bit 0 = A through bit 4 = E |
| reg_b_en | input | 1 | Regulator B enabled |
| ctrl_byte | input | 8 | Control byte: polarities, monitor choice and delay codes |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| pg_pin | output | 1 | Power-good flag pin |
| rst_pin | output | 1 | Reset pin |

## Verification
Some properties hold on every cycle and are checked by assertions:
- a pin drops on the clock after its condition is lost;
- a pin rises only after its count is complete;
- a zero delay qualifies in one clock;
- a control change clears a running count;
- the count never exceeds the longest delay;
- both pins sit at their fail level after the B enable goes low.

Other behaviour can only be shown by the bench scenarios. These scenarios check the exact delay length for every code of both asymmetric tables. They check the monitor choice against every pattern of regulator status, and the level of each pin under both polarities. They also check that after B is disabled the full delay is needed again, and that a control change in the middle of a count adds the whole delay again.

// File: rtl/pwr_sup_pkg.sv
package pwr_sup_pkg;

  localparam int unsigned NUM_REG = 5;
  localparam int unsigned IDX_A   = 0;
  localparam int unsigned IDX_B   = 1;
  localparam int unsigned IDX_C   = 2;
  localparam int unsigned IDX_D   = 3;
  localparam int unsigned IDX_E   = 4;

  localparam int unsigned NUM_CH  = 2;
  localparam int unsigned CH_PG   = 0;
  localparam int unsigned CH_RST  = 1;

  typedef enum logic [1:0] {
    MON_ALL = 2'b00,
    MON_E   = 2'b01,
    MON_C   = 2'b10,
    MON_D   = 2'b11
  } mon_sel_e;

  // Field order is fixed: bit 7 down to bit 0
  typedef struct packed {
    logic       pg_high_good;
    logic       rst_high_good;
    mon_sel_e   mon;
    logic [1:0] pg_code;
    logic [1:0] rst_code;
  } ctrl_t;

  // Power-good delay table
  function automatic int unsigned pg_delay_ticks(logic [1:0] code,
                                                 int unsigned lng,
                                                 int unsigned mid,
                                                 int unsigned sht);
    case (code)
      2'b00:   return lng;
      2'b01:   return mid;
      2'b10:   return sht;
      default: return 0;
    endcase
  endfunction

  // Reset delay table, middle codes swapped relative to power-good
  function automatic int unsigned rst_delay_ticks(logic [1:0] code,
                                                  int unsigned lng,
                                                  int unsigned mid,
                                                  int unsigned sht);
    case (code)
      2'b00:   return lng;
      2'b01:   return sht;
      2'b10:   return mid;
      default: return 0;
    endcase
  endfunction

  function automatic logic monitor_cond(mon_sel_e sel, logic [NUM_REG-1:0] good);
    case (sel)
      MON_ALL: return good[IDX_A] & good[IDX_C] & good[IDX_D] & good[IDX_E];
      MON_E:   return good[IDX_E];
      MON_C:   return good[IDX_C];
      default: return good[IDX_D];
    endcase
  endfunction

endpackage

// File: rtl/pwr_sup_source.sv
module pwr_sup_source
  import pwr_sup_pkg::*;
(
  input  logic [NUM_REG-1:0] good,
  input  mon_sel_e           mon,
  output logic               pg_cond,
  output logic               rst_cond
);

  logic unused_b;

  assign pg_cond  = monitor_cond(mon, good);
  assign rst_cond = good[IDX_A];
  // Regulator B status is not a monitor source; its enable gates elsewhere
  assign unused_b = good[IDX_B];

endmodule

// File: rtl/pwr_sup_qualifier.sv
module pwr_sup_qualifier #(
  parameter int unsigned MAX_CNT = 150,
  parameter int unsigned CW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          cond,
  input  logic          tick,
  input  logic          restart,
  input  logic [CW-1:0] limit,
  output logic          good_o
);

  logic [CW-1:0] cnt_q;
  logic          good_q;

  // Named events for the checks
  logic held;
  logic count_done;

  assign held       = en & cond;
  assign count_done = (cnt_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      good_q <= 1'b0;
    end else if (!held) begin
      cnt_q  <= '0;
      good_q <= 1'b0;
    end else if (!good_q) begin
      if (restart)         cnt_q  <= '0;
      else if (count_done) good_q <= 1'b1;
      else if (tick)       cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign good_o = good_q;

  // R7
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !held |=> !good_q);

  // R6
  rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(good_q) |-> $past(held && count_done && !restart));

  // R6
  zero_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !restart && limit == '0) |=> good_q);

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(MAX_CNT));

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !good_q && restart) |=> (cnt_q == '0 && !good_q));

endmodule

// File: rtl/pwr_sup_pin.sv
module pwr_sup_pin (
  input  logic good,
  input  logic active_high,
  output logic pin
);

  assign pin = active_high ? good : ~good;

endmodule

// File: rtl/pwr_supervisor.sv
module pwr_supervisor
  import pwr_sup_pkg::*;
#(
  parameter int unsigned LONG_MS  = 150,
  parameter int unsigned MID_MS   = 100,
  parameter int unsigned SHORT_MS = 50
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [4:0]   reg_good,
  input  logic         reg_b_en,
  input  logic [7:0]   ctrl_byte,
  input  logic         ms_tick,
  output logic         pg_pin,
  output logic         rst_pin
);

  localparam int unsigned CW = $clog2(LONG_MS + 1);

  ctrl_t        cfg;
  logic [7:0]   ctrl_q;
  logic         cfg_restart;

  logic [NUM_CH-1:0] ch_cond;
  logic [NUM_CH-1:0] ch_good;
  logic [NUM_CH-1:0] ch_pol;
  logic [NUM_CH-1:0] ch_pin;
  logic [CW-1:0]     ch_lim [NUM_CH];

  assign cfg = ctrl_t'(ctrl_byte);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_byte;
  end

  assign cfg_restart = (ctrl_q != ctrl_byte);

  pwr_sup_source u_src (
    .good     (reg_good),
    .mon      (cfg.mon),
    .pg_cond  (ch_cond[CH_PG]),
    .rst_cond (ch_cond[CH_RST])
  );

  assign ch_lim[CH_PG]  = CW'(pg_delay_ticks(cfg.pg_code, LONG_MS, MID_MS, SHORT_MS));
  assign ch_lim[CH_RST] = CW'(rst_delay_ticks(cfg.rst_code, LONG_MS, MID_MS, SHORT_MS));
  assign ch_pol[CH_PG]  = cfg.pg_high_good;
  assign ch_pol[CH_RST] = cfg.rst_high_good;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    pwr_sup_qualifier #(
      .MAX_CNT (LONG_MS),
      .CW      (CW)
    ) u_qual (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (reg_b_en),
      .cond    (ch_cond[ch]),
      .tick    (ms_tick),
      .restart (cfg_restart),
      .limit   (ch_lim[ch]),
      .good_o  (ch_good[ch])
    );

    pwr_sup_pin u_pin (
      .good        (ch_good[ch]),
      .active_high (ch_pol[ch]),
      .pin         (ch_pin[ch])
    );
  end

  assign pg_pin  = ch_pin[CH_PG];
  assign rst_pin = ch_pin[CH_RST];

  // R8
  pg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_b_en |=> (pg_pin != ctrl_byte[7]));

  // R8
  rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_b_en |=> (rst_pin != ctrl_byte[6]));

endmodule

// File: tb/pwr_supervisor_bench.sv
module pwr_supervisor_bench;

  localparam int L = 6;
  localparam int M = 4;
  localparam int S = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] reg_good = '0;
  logic       reg_b_en = 1'b0;
  logic [7:0] ctrl_byte = '0;
  logic       ms_tick = 1'b0;
  logic       pg_pin, rst_pin;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pwr_supervisor #(.LONG_MS(L), .MID_MS(M), .SHORT_MS(S)) u_pwr_supervisor (
    .clk, .rst_n, .reg_good, .reg_b_en, .ctrl_byte, .ms_tick, .pg_pin, .rst_pin
  );

  function automatic int pg_ms(logic [1:0] c);
    int t [4] = '{L, M, S, 0};
    return t[c];
  endfunction

  function automatic int rst_ms(logic [1:0] c);
    int t [4] = '{L, S, M, 0};
    return t[c];
  endfunction

  function automatic bit mon_ok(logic [1:0] sel, logic [4:0] g);
    if (sel == 2'd0) return g[0] && g[2] && g[3] && g[4];
    return g[(sel == 2'd1) ? 4 : (sel == 2'd2) ? 2 : 3];
  endfunction

  // Bench model of the two qualified flags
  int   m_cnt [2];
  bit   m_ok  [2];
  logic [7:0] m_prev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt[0] <= 0; m_cnt[1] <= 0; m_ok[0] <= 0; m_ok[1] <= 0; m_prev <= '0;
    end else begin
      for (int ch = 0; ch < 2; ch++) begin
        bit c; int lim;
        c   = (ch == 0) ? mon_ok(ctrl_byte[5:4], reg_good) : reg_good[0];
        lim = (ch == 0) ? pg_ms(ctrl_byte[3:2]) : rst_ms(ctrl_byte[1:0]);
        if (!reg_b_en || !c) begin
          m_cnt[ch] <= 0; m_ok[ch] <= 0;
        end else if (!m_ok[ch]) begin
          if (ctrl_byte != m_prev)  m_cnt[ch] <= 0;
          else if (m_cnt[ch] >= lim) m_ok[ch] <= 1;
          else if (ms_tick)         m_cnt[ch] <= m_cnt[ch] + 1;
        end
      end
      m_prev <= ctrl_byte;
    end
  end

  task automatic chk(logic act, logic exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    @(negedge clk);
    chk(pg_pin,  ctrl_byte[7] ? m_ok[0] : !m_ok[0], {tag, " pg model"});
    chk(rst_pin, ctrl_byte[6] ? m_ok[1] : !m_ok[1], {tag, " rst model"});
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    // R10: both pins at fail/reset level with default byte
    chk(pg_pin, 1'b1, "R10 pg in reset");
    chk(rst_pin, 1'b1, "R10 rst in reset");
    rst_n = 1'b1;
    step("R10");
    chk(pg_pin, 1'b1, "R10 pg after reset");

    // R4 R5 R6: delay length per code
    ms_tick = 1'b1;
    reg_good = 5'b11111;
    for (int code = 0; code < 4; code++) begin
      int pg_at, rs_at;
      reg_b_en = 1'b0;
      ctrl_byte = {2'b11, 2'b00, code[1:0], code[1:0]};
      step("R8");
      reg_b_en = 1'b1;
      pg_at = -1; rs_at = -1;
      for (int n = 1; n <= L + 4; n++) begin
        step("R6");
        if (pg_at < 0 && pg_pin) pg_at = n;
        if (rs_at < 0 && rst_pin) rs_at = n;
      end
      chk(pg_at == pg_ms(code[1:0]) + 1, 1'b1, "R4 pg delay length");
      chk(rs_at == rst_ms(code[1:0]) + 1, 1'b1, "R5 rst delay length");
    end

    // R1 R2: polarity of settled good pins
    ctrl_byte = 8'h0F; step("R1"); step("R1");
    chk(pg_pin, 1'b0, "R1 low on good");
    chk(rst_pin, 1'b0, "R2 low on good");
    ctrl_byte = 8'hCF; step("R1");
    chk(pg_pin, 1'b1, "R1 high on good");
    chk(rst_pin, 1'b1, "R2 high on good");

    // R3: every monitor choice under every status pattern
    for (int sel = 0; sel < 4; sel++) begin
      ctrl_byte = {2'b11, sel[1:0], 4'b1111};
      for (int p = 0; p < 32; p++) begin
        reg_good = p[4:0];
        step("R3"); step("R3");
        chk(pg_pin, mon_ok(sel[1:0], p[4:0]), "R3 monitor source");
        chk(rst_pin, p[0], "R5 follows A");
      end
    end

    // R7: loss of good drops on the next clock
    reg_good = 5'b11111; ctrl_byte = 8'hC0;
    repeat (L + 3) step("R7");
    chk(pg_pin, 1'b1, "R7 pg settled good");
    reg_good[0] = 1'b0;
    step("R7");
    chk(pg_pin, 1'b0, "R7 pg drop");
    chk(rst_pin, 1'b0, "R7 rst drop");
    reg_good[0] = 1'b1;

    // R8: disable mid-count clears the count
    repeat (3) step("R8");
    reg_b_en = 1'b0; step("R8");
    chk(pg_pin, 1'b0, "R8 pg held");
    reg_b_en = 1'b1;
    repeat (L) step("R8");
    chk(pg_pin, 1'b0, "R8 full delay needed");
    step("R8");
    chk(pg_pin, 1'b1, "R8 good after full delay");

    // R9: control change restarts a running count
    reg_b_en = 1'b0; step("R9"); reg_b_en = 1'b1;
    repeat (4) step("R9");
    ctrl_byte = 8'hE0;
    repeat (L + 1) step("R9");
    chk(pg_pin, 1'b0, "R9 restarted count");
    step("R9");
    chk(pg_pin, 1'b1, "R9 good after restart");
    ctrl_byte = 8'hE1; step("R9");
    chk(pg_pin, 1'b1, "R9 good stays good");

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 8 == 0) reg_good[$urandom % 5] = ~reg_good[$urandom % 5];
      if ($urandom % 10 == 0) reg_good = 5'b11111;
      reg_b_en = ($urandom % 40) != 0;
      if ($urandom % 50 == 0) ctrl_byte = 8'($urandom);
      ms_tick = $urandom % 2;
      step("RND");
    end

    finish_run();
  end

endmodule